// File: doc/BRIEF.md
# Spread Fractional-Duty Pulse Generator

This block produces a pulse-width-modulated bit stream whose high time is a programmable fraction of a period of M time slots. It does not emit the high slots as one block at the start of the period. An error accumulator places them as evenly as the integer grid allows, so the stream toggles as often as possible and most of the ripple energy sits at high frequencies. An 8-bit fractional duty refines the average further. A fractional accumulator raises the high count of selected periods from N to N+1, so that over 256 periods the average high count is N + F/256.

Each clock the block emits a word of several consecutive time slots. This lets a downstream serializer run the stream at a bit rate several times the fabric clock. A new duty and period are written through a single load strobe. They wait in a pending slot and are only put into use at the next period boundary, so a period is never cut short or mixed.

Top module: `spwm_gen`

## Requirements
- R1: While `rst` is high, and for as long as no load has been applied, `pwm_word` reads all zeros. Reset selects N=0, fraction 0 and a period of 2 slots.
- R2: Every clock `pwm_word` carries LANES consecutive time slots of the stream. Bit 0 is the earliest slot, and the slots of consecutive words follow each other without gaps. The first word after reset starts at a period boundary.
- R3: With a zero fraction, every period of M slots holds exactly N high slots (for N ≤ M).
- R4: Within a period using high count n, slot i (0-based) is high exactly when floor((i+1)·n/M) > floor(i·n/M).
- R5: An 8-bit fraction accumulator is cleared whenever a new setting is put into use. At the start of every period it adds F. When the sum reaches 256 it keeps the sum minus 256, and that period uses n=N+1; otherwise it keeps the sum and n=N.
- R6: A period with n=0 is entirely low. A period with n ≥ M, including any N above M, is entirely high because n is limited to M.
- R7: `cfg_load` captures `cfg_high`, `cfg_frac` and `cfg_period` into a pending slot. The pending values are first used at the next period boundary that starts in a later clock. A second load before that boundary replaces the first.
- R8: A programmed period of 0 or 1 is treated as a period of 2.
- R9: Period boundaries that fall inside a word, because M is not a multiple of LANES, are handled within that word. A period never loses or gains slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Strobe that captures the three configuration inputs |
| cfg_high | input | 16 | Integer high count N per period |
| cfg_frac | input | 8 | Fractional high count, in units of 1/256 |
| cfg_period | input | 16 | Period length M in slots |
| pwm_word | output | 8 | LANES output slots for this clock, bit 0 earliest |

## Verification
A corrupted spreading accumulator shows up within the same period. The high slots move away from the floor-division positions, and the count per period no longer matches N. Both are visible in the next output word after the fault. Dither errors appear in the per-period count as soon as the fraction accumulator should carry. For a small fraction this can take up to 256 periods, so the bench runs a full accumulator cycle and checks the total. A pending setting applied at the wrong slot changes the pattern one word early or one word late, which word-exact comparison against an independent floor-division model catches at once.

// File: rtl/spwm_pkg.sv
package spwm_pkg;
  localparam int CNT_W   = 16;
  localparam int FRAC_W  = 8;
  localparam int PER_MIN = 2;

  typedef struct packed {
    logic [CNT_W-1:0]  high;
    logic [FRAC_W-1:0] frac;
    logic [CNT_W-1:0]  per;
  } cfg_t;

  typedef struct packed {
    logic [CNT_W-1:0]  acc;
    logic [CNT_W-1:0]  pos;
    logic [CNT_W-1:0]  per;
    logic [CNT_W-1:0]  n;
    logic [CNT_W-1:0]  high;
    logic [FRAC_W-1:0] frac;
    logic [FRAC_W-1:0] facc;
  } slot_st_t;
endpackage

// File: rtl/spwm_pending.sv
module spwm_pending
  import spwm_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  input  cfg_t cfg_i,
  input  logic live_ret_i,
  output cfg_t pend_o,
  output logic live_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_o <= '0;
      live_o <= 1'b0;
    end else if (load_i) begin
      pend_o <= cfg_i;
      live_o <= 1'b1;
    end else begin
      live_o <= live_ret_i;
    end
  end
endmodule

// File: rtl/spwm_period_sel.sv
module spwm_period_sel
  import spwm_pkg::*;
(
  input  logic     bnd_i,
  input  slot_st_t st_i,
  input  cfg_t     pend_i,
  input  logic     pend_live_i,
  output slot_st_t cur_o,
  output logic     pend_live_o
);
  logic [FRAC_W-1:0] fbase;
  logic [FRAC_W:0]   fsum;
  logic [CNT_W:0]    nsum;

  always_comb begin
    cur_o       = st_i;
    pend_live_o = pend_live_i;
    fbase       = st_i.facc;
    if (bnd_i && pend_live_i) begin
      cur_o.high  = pend_i.high;
      cur_o.frac  = pend_i.frac;
      cur_o.per   = (pend_i.per < CNT_W'(PER_MIN)) ? CNT_W'(PER_MIN) : pend_i.per;
      fbase       = '0;
      pend_live_o = 1'b0;
    end
    fsum = {1'b0, fbase} + {1'b0, cur_o.frac};
    nsum = {1'b0, cur_o.high} + {{CNT_W{1'b0}}, fsum[FRAC_W]};
    if (bnd_i) begin
      cur_o.facc = fsum[FRAC_W-1:0];
      cur_o.n    = (nsum > {1'b0, cur_o.per}) ? cur_o.per : nsum[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/spwm_spread_step.sv
module spwm_spread_step
  import spwm_pkg::*;
(
  input  logic [CNT_W-1:0] acc_i,
  input  logic [CNT_W-1:0] n_i,
  input  logic [CNT_W-1:0] per_i,
  output logic             bit_o,
  output logic [CNT_W-1:0] acc_o
);
  logic [CNT_W:0] sum;
  logic [CNT_W:0] rem;

  always_comb begin
    sum   = {1'b0, acc_i} + {1'b0, n_i};
    rem   = sum - {1'b0, per_i};
    bit_o = (sum >= {1'b0, per_i});
    acc_o = bit_o ? rem[CNT_W-1:0] : sum[CNT_W-1:0];
  end
endmodule

// File: rtl/spwm_lane.sv
module spwm_lane
  import spwm_pkg::*;
(
  input  slot_st_t st_i,
  input  cfg_t     pend_i,
  input  logic     pend_live_i,
  output slot_st_t st_o,
  output logic     pend_live_o,
  output logic     bit_o,
  output logic     bnd_o
);
  slot_st_t         cur;
  logic [CNT_W-1:0] acc_base;
  logic [CNT_W-1:0] acc_nxt;

  assign bnd_o    = (st_i.pos == '0);
  assign acc_base = bnd_o ? '0 : st_i.acc;

  spwm_period_sel u_sel (
    .bnd_i       (bnd_o),
    .st_i        (st_i),
    .pend_i      (pend_i),
    .pend_live_i (pend_live_i),
    .cur_o       (cur),
    .pend_live_o (pend_live_o)
  );

  spwm_spread_step u_step (
    .acc_i (acc_base),
    .n_i   (cur.n),
    .per_i (cur.per),
    .bit_o (bit_o),
    .acc_o (acc_nxt)
  );

  always_comb begin
    st_o     = cur;
    st_o.acc = acc_nxt;
    st_o.pos = (st_i.pos == cur.per - CNT_W'(1)) ? '0 : st_i.pos + CNT_W'(1);
  end
endmodule

// File: rtl/spwm_gen.sv
module spwm_gen
  import spwm_pkg::*;
#(
  parameter int LANES        = 8,
  parameter int RESET_PERIOD = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_load,
  input  logic [CNT_W-1:0]  cfg_high,
  input  logic [FRAC_W-1:0] cfg_frac,
  input  logic [CNT_W-1:0]  cfg_period,
  output logic [LANES-1:0]  pwm_word
);
  slot_st_t          st_q;
  slot_st_t          st_chain [LANES+1];
  logic [LANES:0]    live_chain;
  logic [LANES-1:0]  word_d;
  logic [LANES-1:0]  bnd_vec;
  cfg_t              cfg_in;
  cfg_t              pend;
  logic              pend_live;

  logic [CNT_W-1:0]  act_n;
  logic [CNT_W-1:0]  act_per;
  logic [CNT_W-1:0]  act_acc;
  logic              bnd_any;

  assign cfg_in = '{high: cfg_high, frac: cfg_frac, per: cfg_period};

  spwm_pending u_pend (
    .clk        (clk),
    .rst        (rst),
    .load_i     (cfg_load),
    .cfg_i      (cfg_in),
    .live_ret_i (live_chain[LANES]),
    .pend_o     (pend),
    .live_o     (pend_live)
  );

  assign st_chain[0]   = st_q;
  assign live_chain[0] = pend_live;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    spwm_lane u_lane (
      .st_i        (st_chain[g]),
      .pend_i      (pend),
      .pend_live_i (live_chain[g]),
      .st_o        (st_chain[g+1]),
      .pend_live_o (live_chain[g+1]),
      .bit_o       (word_d[g]),
      .bnd_o       (bnd_vec[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= '0;
      st_q.per <= CNT_W'(RESET_PERIOD);
      pwm_word <= '0;
    end else begin
      st_q     <= st_chain[LANES];
      pwm_word <= word_d;
    end
  end

  assign act_n   = st_q.n;
  assign act_per = st_q.per;
  assign act_acc = st_q.acc;
  assign bnd_any = |bnd_vec;
endmodule

// File: rtl/spwm_gen_chk.sv
module spwm_gen_chk
  import spwm_pkg::*;
#(
  parameter int LANES = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [LANES-1:0] pwm_word,
  input logic [CNT_W-1:0] act_n,
  input logic [CNT_W-1:0] act_per,
  input logic [CNT_W-1:0] act_acc,
  input logic             bnd_any
);
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> pwm_word == '0);

  assert_acc_in_range_R4: assert property (@(posedge clk) disable iff (rst)
    act_acc < act_per);

  assert_per_floor_R8: assert property (@(posedge clk) disable iff (rst)
    act_per >= CNT_W'(PER_MIN));

  assert_n_clamped_R6: assert property (@(posedge clk) disable iff (rst)
    act_n <= act_per);

  assert_all_low_R6: assert property (@(posedge clk) disable iff (rst)
    (act_n == '0 && !bnd_any) |=> pwm_word == '0);

  assert_all_high_R6: assert property (@(posedge clk) disable iff (rst)
    (act_n == act_per && !bnd_any) |=> &pwm_word);

  assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !bnd_any |=> ($stable(act_per) && $stable(act_n)));
endmodule

bind spwm_gen spwm_gen_chk #(.LANES(LANES)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .pwm_word (pwm_word),
  .act_n    (act_n),
  .act_per  (act_per),
  .act_acc  (act_acc),
  .bnd_any  (bnd_any)
);

// File: tb/tb_spwm_gen.sv
module tb_spwm_gen;
  localparam int LANES = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_load = 1'b0;
  logic [15:0] cfg_high = '0;
  logic [7:0]  cfg_frac = '0;
  logic [15:0] cfg_period = '0;
  logic [LANES-1:0] pwm_word;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // reference model state (floor-division placement)
  longint m_pos, m_per, m_n, m_high, m_frac, m_facc;
  longint p_high, p_frac, p_per;
  bit     p_live;
  logic [LANES-1:0] exp_word = '0;

  always #5 clk = ~clk;

  spwm_gen #(.LANES(LANES)) dut (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_high(cfg_high),
    .cfg_frac(cfg_frac), .cfg_period(cfg_period), .pwm_word(pwm_word)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_pos = 0; m_per = 2; m_n = 0; m_high = 0; m_frac = 0; m_facc = 0;
      p_live = 0; p_high = 0; p_frac = 0; p_per = 0;
      exp_word = '0;
    end else begin
      for (int i = 0; i < LANES; i++) begin
        if (m_pos == 0) begin
          if (p_live) begin
            m_high = p_high; m_frac = p_frac;
            m_per = (p_per < 2) ? 2 : p_per;
            m_facc = 0; p_live = 0;
          end
          m_facc = m_facc + m_frac;
          m_n = m_high;
          if (m_facc >= 256) begin m_facc = m_facc - 256; m_n = m_n + 1; end
          if (m_n > m_per) m_n = m_per;
        end
        exp_word[i] = (((m_pos + 1) * m_n) / m_per) != ((m_pos * m_n) / m_per);
        m_pos = (m_pos + 1 == m_per) ? 0 : m_pos + 1;
      end
      if (cfg_load) begin
        p_high = cfg_high; p_frac = cfg_frac; p_per = cfg_period; p_live = 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // word-exact scoreboard against the floor-division model (R2, R4)
  always @(negedge clk) begin
    chk(pwm_word === exp_word, "R2 scoreboard word", pwm_word, exp_word);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic apply_reset();
    @(negedge clk); rst = 1'b1; cfg_load = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic do_load(input int h, input int f, input int p);
    @(negedge clk);
    cfg_high = 16'(h); cfg_frac = 8'(f); cfg_period = 16'(p); cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(pwm_word == '0, "R1 word in reset", pwm_word, 0);
    rst = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk(pwm_word == '0, "R1 default output low", pwm_word, 0);
    end
  endtask

  task automatic t_spread();
    int ones;
    apply_reset();
    do_load(5, 0, 16);
    @(negedge clk); chk(pwm_word == 8'h48, "R4 R2 first half", pwm_word, 8'h48);
    @(negedge clk); chk(pwm_word == 8'h92, "R4 R2 second half", pwm_word, 8'h92);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); ones = $countones(pwm_word);
      @(negedge clk); ones += $countones(pwm_word);
      chk(ones == 5, "R3 high count per period", ones, 5);
    end
  endtask

  task automatic t_dither();
    int total;
    int exp_c [4] = '{3, 4, 3, 4};
    apply_reset();
    do_load(3, 128, 8);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk($countones(pwm_word) == exp_c[k], "R5 dithered count", $countones(pwm_word), exp_c[k]);
    end
    apply_reset();
    do_load(1, 1, 8);
    total = 0;
    for (int k = 0; k < 256; k++) begin
      @(negedge clk); total += $countones(pwm_word);
    end
    chk(total == 257, "R5 count over 256 periods", total, 257);
  endtask

  task automatic t_limits();
    apply_reset();
    do_load(0, 0, 8);
    repeat (3) begin
      @(negedge clk); chk(pwm_word == 8'h00, "R6 zero duty low", pwm_word, 0);
    end
    apply_reset();
    do_load(8, 255, 8);
    repeat (3) begin
      @(negedge clk); chk(pwm_word == 8'hFF, "R6 full duty high", pwm_word, 8'hFF);
    end
    apply_reset();
    do_load(20, 0, 8);
    repeat (2) begin
      @(negedge clk); chk(pwm_word == 8'hFF, "R6 N above M high", pwm_word, 8'hFF);
    end
  endtask

  task automatic t_min_period();
    apply_reset();
    do_load(1, 0, 0);
    repeat (2) begin
      @(negedge clk); chk(pwm_word == 8'hAA, "R8 period 0 as 2", pwm_word, 8'hAA);
    end
    apply_reset();
    do_load(1, 0, 1);
    @(negedge clk); chk(pwm_word == 8'hAA, "R8 period 1 as 2", pwm_word, 8'hAA);
  endtask

  task automatic t_deferred();
    apply_reset();
    do_load(0, 0, 16);
    @(negedge clk);
    do_load(16, 0, 16);
    @(negedge clk); chk(pwm_word == 8'h00, "R7 held until boundary", pwm_word, 0);
    @(negedge clk); chk(pwm_word == 8'hFF, "R7 applied at boundary", pwm_word, 8'hFF);
    // second load before the boundary replaces the first
    apply_reset();
    do_load(0, 0, 16);
    @(negedge clk);
    @(negedge clk);
    cfg_high = 16'd16; cfg_frac = 8'd0; cfg_period = 16'd16; cfg_load = 1'b1;
    @(negedge clk);
    cfg_high = 16'd4;
    @(negedge clk);
    cfg_load = 1'b0;
    chk(pwm_word == 8'h00, "R7 mid period unchanged", pwm_word, 0);
    @(negedge clk); chk(pwm_word == 8'h88, "R7 latest load wins", pwm_word, 8'h88);
    @(negedge clk); chk(pwm_word == 8'h88, "R7 latest load second half", pwm_word, 8'h88);
  endtask

  task automatic t_midword();
    int total;
    apply_reset();
    do_load(2, 0, 5);
    @(negedge clk); chk(pwm_word == 8'h94, "R9 boundary inside word", pwm_word, 8'h94);
    total = $countones(pwm_word);
    repeat (4) begin
      @(negedge clk); total += $countones(pwm_word);
    end
    chk(total == 16, "R9 eight periods over five words", total, 16);
  endtask

  initial begin
    t_reset();
    t_spread();
    t_dither();
    t_limits();
    t_min_period();
    t_deferred();
    t_midword();
    @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule